// File: doc/BRIEF.md
# Double-Buffered Stream Payload Table

This block keeps the payload allocation table that a multi-stream display sink uses to tell its streams apart on the link. The table is held twice. A host fills a pending copy through a simple single-cycle register bus. The link layer only ever sees the active copy. Moving the pending copy into the active copy is called a commit.

A commit happens in one of two ways. The first is a force strobe, which commits at once. The second is an update request level, which arms the block. An armed block commits on the next allocation-change trigger (ACT) pulse from the link layer. After a deferred commit, a sticky acknowledge flag in a read-only status word stays set until the host drops the request.

The same register space also holds a framing-mode enable and one payload ID per stream. Payload ID values 1 to 15 are the meaningful ones, and the block stores each ID as written.

Top module: `payload_table_sync`

## Requirements
- R1: The control word is at address 0. Bit 0 is the framing enable and drives `mst_en_o` (1 selects multi-stream framing, 0 selects single-stream framing). The four 4-bit stream payload IDs are at bits 7:4 (stream 0), 11:8 (stream 1), 15:12 (stream 2) and 19:16 (stream 3). They drive `stream_id_o`, with stream 0 in the low nibble. All other control bits read as zero.
- R2: The pending table is eight 32-bit words at addresses 8 to 15. A read of those addresses returns the pending copy.
- R3: The active table (`active_tbl_o`, word k at bits 32k+31:32k) changes only on a commit. Writes to the pending table alone leave it untouched.
- R4: A write to address 2 with bit 1 set is a force. At that clock edge, the pending table as it stood before the edge is copied into the active table. Bit 1 is a strobe and reads back as 0.
- R5: Bit 0 of address 2 is the update request level, and it reads back as written. Writing it from 0 to 1 arms the block. The first `act_i` pulse while the block is armed copies the pending table into the active table at that edge and disarms the block.
- R6: An `act_i` pulse while the block is not armed changes nothing. A request that is held high commits only once.
- R7: The acknowledge flag is bit 30 of the read-only status word at address 1, and every other status bit reads 0. The flag is set by a deferred commit.
- R8: The acknowledge flag stays set while the request stays high. It clears when the request is written to 0, and that write also disarms the block.
- R9: A force while a request is armed commits immediately and leaves the request armed. A later `act_i` then commits again and sets the acknowledge flag.
- R10: Reset clears both table copies, the payload IDs, the framing enable, the request, the armed state and the acknowledge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| act_i | input | 1 | Single-cycle allocation-change trigger pulse |
| mst_en_o | output | 1 | Framing mode: 1 multi-stream, 0 single-stream |
| stream_id_o | output | 16 | Payload IDs, stream 0 in bits 3:0 |
| active_tbl_o | output | 256 | Active payload table, eight words |

## Verification
The checker watches every cycle for the following:
- the active table moves only in the cycle after a force or an armed ACT, and it then equals the pending copy from before that edge;
- a deferred commit disarms the block;
- a force leaves an armed request armed;
- the acknowledge flag rises only after an armed ACT and is never set while the request is low;
- the status word has no stray bits set.

Some behaviour can only be shown by the bench scenarios:
- the control field layout and the zero padding;
- the pending table reading back as written;
- the strobe bit reading back as zero;
- an ACT with no request having no effect;
- the full sequence of a force inside a pending request followed by a deferred commit;
- a reset in the middle of a run.

// File: rtl/ptab_pkg.sv
package ptab_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned ID_LSB    = 4;
  localparam int unsigned REQ_BIT   = 0;
  localparam int unsigned FORCE_BIT = 1;
  localparam int unsigned ACK_BIT   = 30;
  localparam int unsigned CTL_ADDR  = 0;
  localparam int unsigned STAT_ADDR = 1;
  localparam int unsigned UPD_ADDR  = 2;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/ptab_regs.sv
module ptab_regs
  import ptab_pkg::*;
#(
  parameter int unsigned NUM_WORDS   = 8,
  parameter int unsigned NUM_STREAMS = 4,
  parameter int unsigned ID_W        = 4,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned TAB_BASE    = 8,
  localparam int unsigned IDS_W      = NUM_STREAMS * ID_W,
  localparam int unsigned TBL_W      = NUM_WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  input  logic              ack_i,
  output word_t             rdata_o,
  output logic              en_o,
  output logic [IDS_W-1:0]  ids_o,
  output logic              req_o,
  output logic              req_rise_o,
  output logic              req_fall_o,
  output logic              force_o,
  output logic [TBL_W-1:0]  pend_o
);
  logic             en_q, req_q;
  logic [IDS_W-1:0] ids_q;
  word_t            pend_q [NUM_WORDS];
  logic             ctl_we, upd_we;

  assign ctl_we = we_i && (addr_i == ADDR_W'(CTL_ADDR));
  assign upd_we = we_i && (addr_i == ADDR_W'(UPD_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ids_q <= '0;
      req_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        en_q  <= wdata_i[EN_BIT];
        ids_q <= wdata_i[ID_LSB +: IDS_W];
      end
      if (upd_we) req_q <= wdata_i[REQ_BIT];
    end
  end

  assign force_o    = upd_we &  wdata_i[FORCE_BIT];
  assign req_rise_o = upd_we &  wdata_i[REQ_BIT] & ~req_q;
  assign req_fall_o = upd_we & ~wdata_i[REQ_BIT] &  req_q;
  assign en_o       = en_q;
  assign ids_o      = ids_q;
  assign req_o      = req_q;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= '0;
      else if (we_i && (addr_i == ADDR_W'(TAB_BASE + i))) pend_q[i] <= wdata_i;
    end
    assign pend_o[i*DATA_W +: DATA_W] = pend_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTL_ADDR)) begin
      rdata_o[EN_BIT]              = en_q;
      rdata_o[ID_LSB +: IDS_W]     = ids_q;
    end else if (addr_i == ADDR_W'(STAT_ADDR)) begin
      rdata_o[ACK_BIT]             = ack_i;
    end else if (addr_i == ADDR_W'(UPD_ADDR)) begin
      rdata_o[REQ_BIT]             = req_q;  // force strobe reads 0
    end else begin
      for (int i = 0; i < NUM_WORDS; i++)
        if (addr_i == ADDR_W'(TAB_BASE + i)) rdata_o = pend_q[i];
    end
  end
endmodule

// File: rtl/ptab_commit.sv
module ptab_commit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic req_i,
  input  logic req_rise_i,
  input  logic req_fall_i,
  input  logic force_i,
  output logic armed_o,
  output logic ack_o,
  output logic load_o
);
  logic armed_q, ack_q, act_hit;

  assign act_hit = armed_q & act_i;
  assign load_o  = force_i | act_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      // rise arms; fall or a consumed ACT disarms; force leaves arming alone
      if (req_rise_i)                armed_q <= 1'b1;
      else if (req_fall_i || act_hit) armed_q <= 1'b0;
      ack_q <= req_i & ~req_fall_i & (ack_q | act_hit);
    end
  end

  assign armed_o = armed_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/ptab_active.sv
module ptab_active
  import ptab_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned TBL_W    = NUM_WORDS * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TBL_W-1:0] pend_i,
  output logic [TBL_W-1:0] tbl_o
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    word_t word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     word_q <= '0;
      else if (load_i) word_q <= pend_i[i*DATA_W +: DATA_W];
    end
    assign tbl_o[i*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/payload_table_sync.sv
module payload_table_sync
  import ptab_pkg::*;
#(
  parameter int unsigned NUM_WORDS   = 8,
  parameter int unsigned NUM_STREAMS = 4,
  parameter int unsigned ID_W        = 4,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned TAB_BASE    = 8,
  localparam int unsigned IDS_W      = NUM_STREAMS * ID_W,
  localparam int unsigned TBL_W      = NUM_WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              act_i,
  output logic              mst_en_o,
  output logic [IDS_W-1:0]  stream_id_o,
  output logic [TBL_W-1:0]  active_tbl_o
);
  logic             req_s, req_rise_s, req_fall_s, force_s;
  logic             armed_s, ack_s, load_s;
  logic [TBL_W-1:0] pend_s;

  ptab_regs #(
    .NUM_WORDS(NUM_WORDS), .NUM_STREAMS(NUM_STREAMS), .ID_W(ID_W),
    .ADDR_W(ADDR_W), .TAB_BASE(TAB_BASE)
  ) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .ack_i      (ack_s),
    .rdata_o,
    .en_o       (mst_en_o),
    .ids_o      (stream_id_o),
    .req_o      (req_s),
    .req_rise_o (req_rise_s),
    .req_fall_o (req_fall_s),
    .force_o    (force_s),
    .pend_o     (pend_s)
  );

  ptab_commit u_commit (
    .clk_i, .rst_ni, .act_i,
    .req_i      (req_s),
    .req_rise_i (req_rise_s),
    .req_fall_i (req_fall_s),
    .force_i    (force_s),
    .armed_o    (armed_s),
    .ack_o      (ack_s),
    .load_o     (load_s)
  );

  ptab_active #(.NUM_WORDS(NUM_WORDS)) u_active (
    .clk_i, .rst_ni,
    .load_i (load_s),
    .pend_i (pend_s),
    .tbl_o  (active_tbl_o)
  );
endmodule

// File: rtl/payload_table_sync_chk.sv
module payload_table_sync_chk
  import ptab_pkg::*;
#(
  parameter int unsigned TBL_W  = 256,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              act_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic              force_i,
  input logic              armed_i,
  input logic              ack_i,
  input logic              req_i,
  input logic              req_fall_i,
  input logic [TBL_W-1:0]  pend_i,
  input logic [TBL_W-1:0]  tbl_i
);
  word_t stat_mask;
  always_comb begin
    stat_mask = '1;
    stat_mask[ACK_BIT] = 1'b0;
  end

  a_r4_force_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> tbl_i == $past(pend_i));

  a_r5_act_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && act_i) |=> tbl_i == $past(pend_i));

  a_r3_table_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !(armed_i && act_i)) |=> $stable(tbl_i));

  a_r6_commit_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && act_i) |=> !armed_i);

  a_r7_ack_after_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_i) |-> $past(armed_i && act_i));

  a_r7_status_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(STAT_ADDR)) |-> (rdata_i & stat_mask) == '0);

  a_r8_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_i);

  a_r9_force_keeps_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && armed_i && !act_i && !req_fall_i) |=> armed_i);
endmodule

bind payload_table_sync payload_table_sync_chk #(.TBL_W(TBL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .act_i      (act_i),
  .addr_i     (addr_i),
  .rdata_i    (rdata_o),
  .force_i    (force_s),
  .armed_i    (armed_s),
  .ack_i      (ack_s),
  .req_i      (req_s),
  .req_fall_i (req_fall_s),
  .pend_i     (pend_s),
  .tbl_i      (active_tbl_o)
);

// File: tb/payload_table_sync_test.sv
`timescale 1ns/1ps
module payload_table_sync_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0, act = 1'b0;
  logic [3:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         mst_en;
  logic [15:0]  ids;
  logic [255:0] active;

  int checks = 0, errors = 0;

  // reference state
  logic [31:0] m_pend [8];
  logic [31:0] m_act  [8];
  logic        m_en, m_req, m_arm, m_ack;
  logic [15:0] m_ids;

  always #5 clk = ~clk;

  payload_table_sync uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .act_i(act), .mst_en_o(mst_en), .stream_id_o(ids),
    .active_tbl_o(active)
  );

  task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin m_pend[i] = '0; m_act[i] = '0; end
    m_en = 0; m_req = 0; m_arm = 0; m_ack = 0; m_ids = '0;
  endtask

  function automatic logic [255:0] m_flat();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = m_act[i];
    return v;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic [31:0] v = '0;
    if (a == 0) begin v[0] = m_en; v[19:4] = m_ids; end
    else if (a == 1) v[30] = m_ack;
    else if (a == 2) v[0] = m_req;
    else if (a >= 8) v = m_pend[a - 8];
    return v;
  endfunction

  task automatic m_step(input logic w, input logic [3:0] a, input logic [31:0] d, input logic p);
    logic upd, frc, cmt, rise, fall;
    upd  = w && a == 2;
    frc  = upd && d[1];
    cmt  = m_arm && p;
    rise = upd && d[0] && !m_req;
    fall = upd && !d[0] && m_req;
    if (frc || cmt) for (int i = 0; i < 8; i++) m_act[i] = m_pend[i];
    m_ack = m_req && !fall && (m_ack || cmt);
    if (rise) m_arm = 1;
    else if (fall || cmt) m_arm = 0;
    if (upd) m_req = d[0];
    if (w && a == 0) begin m_en = d[0]; m_ids = d[19:4]; end
    if (w && a >= 8) m_pend[a - 8] = d;
  endtask

  task automatic cmp_state(input string tag);
    check({tag, " active"}, active, m_flat());
    check({tag, " mst_en"}, 256'(mst_en), 256'(m_en));
    check({tag, " ids"}, 256'(ids), 256'(m_ids));
  endtask

  task automatic cyc(input string tag, input logic w, input logic [3:0] a,
                     input logic [31:0] d, input logic p);
    we = w; addr = a; wdata = d; act = p;
    @(posedge clk);
    m_step(w, a, d, p);
    @(negedge clk);
    we = 0; act = 0;
    cmp_state(tag);
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    we = 0; addr = a;
    #1;
    check({tag, " read"}, 256'(rdata), 256'(m_read(a)));
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0);
  endtask

  task automatic load_pend(input string tag, input logic [31:0] seed);
    for (int i = 0; i < 8; i++) cyc(tag, 1, 4'(8 + i), seed ^ (32'h0101_0101 * i), 0);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_reset();
    repeat (2) @(negedge clk);
    cmp_state("R10 reset");
    rd("R10 reset ctl", 0); rd("R10 reset stat", 1); rd("R10 reset upd", 2); rd("R10 reset tab", 9);
    rst_n = 1;

    // R1 field layout and padding
    cyc("R1 ctl all ones", 1, 0, 32'hFFFF_FFFF, 0);
    rd("R1 ctl pad", 0);
    cyc("R1 ctl ids", 1, 0, 32'h0004_3211, 0);
    rd("R1 ctl ids", 0);
    cyc("R1 sst", 1, 0, 32'h000A_BCD0, 0);
    rd("R1 sst", 0);

    // R2/R3 pending fill, readback, active untouched
    load_pend("R3 fill", 32'hA5A0_0000);
    for (int i = 0; i < 8; i++) rd("R2 pend", 4'(8 + i));

    // R6 ACT without request
    cyc("R6 stray act", 0, 0, 0, 1);
    idle("R6 idle", 2);

    // R4 force
    cyc("R4 force", 1, 2, 32'h2, 0);
    rd("R4 strobe reads 0", 2);
    rd("R7 no ack after force", 1);

    // R5 deferred commit
    load_pend("R3 refill", 32'h5C00_1234);
    cyc("R5 arm", 1, 2, 32'h1, 0);
    idle("R5 wait", 3);
    rd("R5 req level", 2);
    cyc("R5 act", 0, 0, 0, 1);
    rd("R7 ack set", 1);
    // R6 held request commits once
    load_pend("R6 refill", 32'h0F0F_7700);
    cyc("R6 second act", 0, 0, 0, 1);
    rd("R8 ack held", 1);
    cyc("R8 drop req", 1, 2, 32'h0, 0);
    rd("R8 ack cleared", 1);
    cyc("R6 act after drop", 0, 0, 0, 1);

    // R9 force inside an armed request
    cyc("R9 arm", 1, 2, 32'h1, 0);
    cyc("R9 force", 1, 2, 32'h3, 0);
    rd("R9 no ack yet", 1);
    load_pend("R9 refill", 32'h3300_CC11);
    cyc("R9 act", 0, 0, 0, 1);
    rd("R9 ack", 1);
    cyc("R9 drop", 1, 2, 32'h0, 0);

    // R5 ACT coincident with rising request does not commit
    load_pend("R5 refill", 32'h7777_0001);
    we = 1; addr = 2; wdata = 32'h1; act = 1;
    @(posedge clk); m_step(1, 2, 32'h1, 1);
    @(negedge clk); we = 0; act = 0;
    cmp_state("R5 act with rise");
    cyc("R5 late act", 0, 0, 0, 1);
    rd("R7 late ack", 1);

    // R10 reset mid run
    rst_n = 0; m_reset();
    #1;
    cmp_state("R10 mid reset");
    rd("R10 mid stat", 1); rd("R10 mid upd", 2); rd("R10 mid tab", 12);
    @(negedge clk); rst_n = 1;
    idle("R10 after reset", 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule